// File: doc/BRIEF.md
# Delayed Read Prefetch Controller

This block handles reads that cross a two-port bus bridge as delayed reads. A read from the initiator side is never completed in the cycle it arrives. The block latches the command, DWORD address and byte enables and answers the initiator with retry. It then issues a burst request on the target side, collects the returned data in a local buffer, and hands that data over when the initiator repeats the identical request.

A classifier sends each read down one of two paths.
- **Prefetchable path.** Memory Read Line and Memory Read Multiple always take it. A plain Memory Read takes it when its address lies inside the prefetchable window. On this path the block fetches several DWORDs speculatively and drives all four byte enables on the target side.
- **Non-prefetchable path.** I/O reads, configuration reads and plain memory reads outside the window take it. On this path the block fetches exactly one DWORD, passes the initiator's byte enables through unchanged, and disconnects the initiator after that single word.

The prefetch length is first set by the command. It is then clipped to the free buffer space reported by the surrounding bridge, and cut so that the burst never crosses a 4 KB page.

Top module: `dly_read_ctrl`

## Requirements
- R1: Commands 4'b1110 (line read) and 4'b1100 (multiple read) always take the prefetchable path, whatever the window holds.
- R2: Command 4'b0110 (memory read) takes the prefetchable path only when the window key, bits [29:18] of the DWORD address, satisfies base ≤ key ≤ limit. Otherwise it takes the non-prefetchable path.
- R3: Commands 4'b0010 (I/O read) and 4'b1010 (configuration read) always take the non-prefetchable path.
- R4: On the prefetchable path, `tgt_be` is 4'b1111 whatever byte enables the initiator presented.
- R5: On the non-prefetchable path, `tgt_len` is 1 and `tgt_be` equals the initiator's byte enables.
- R6: Before clipping, the prefetch length runs to the end of the current 8-DWORD line for commands 4'b0110 and 4'b1110. For command 4'b1100 it runs to the end of the next line. The line offset is address bits [2:0].
- R7: The prefetch length is clipped to `free_dw`. It is also clipped so that the burst ends at or before the next 1024-DWORD (4 KB) boundary, using address bits [9:0].
- R8: In idle state, a read request is latched and answered with `ini_retry` one cycle later. `tgt_req` then rises with the latched command and address, and holds steady until `tgt_ack`.
- R9: While a delayed request is outstanding and its data is not all back, every read request is retried, and the outstanding entry is not replaced. Once the data is complete, a request that differs in command, address or byte enables is retried and delivers no data.
- R10: After all data has returned, the identical request is not retried. From the next cycle the buffered words are delivered in order, one per cycle on `ini_dv`, with `ini_last` marking the final word (disconnect). The non-prefetchable path delivers one word.
- R11: A request whose command is not one of the five read codes is ignored: no retry and no target request.
- R12: A read that arrives in idle state while `free_dw` is 0 is retried and not latched, and no target request follows.
- R13: The window is disabled when base > limit. Every plain memory read then takes the non-prefetchable path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ini_req | input | 1 | Initiator presents a request this cycle |
| ini_cmd | input | 4 | Initiator command code |
| ini_addr | input | 30 | Initiator DWORD address |
| ini_be | input | 4 | Initiator byte enables, active high |
| ini_retry | output | 1 | Retry answer, one cycle after the request |
| ini_dv | output | 1 | Read data word valid towards the initiator |
| ini_data | output | 32 | Read data word |
| ini_last | output | 1 | Final word; initiator is disconnected after it |
| win_base | input | 12 | Prefetchable window base, 1 MB granules |
| win_limit | input | 12 | Prefetchable window limit, 1 MB granules |
| free_dw | input | 5 | Free read-buffer space in DWORDs |
| tgt_req | output | 1 | Target-side burst request |
| tgt_cmd | output | 4 | Forwarded command code |
| tgt_addr | output | 30 | Burst start DWORD address |
| tgt_be | output | 4 | Byte enables for every target data phase |
| tgt_len | output | 5 | Burst length in DWORDs |
| tgt_ack | input | 1 | Target side accepts the burst request |
| tgt_rvalid | input | 1 | Returned data word valid |
| tgt_rdata | input | 32 | Returned data word |

## Verification
The bench builds the block with its default parameters: a 30-bit DWORD address, 8-DWORD lines, a 16-word buffer and a 1024-DWORD page. With these values a multiple read from a line start fills the whole buffer. A multiple read placed four DWORDs before a page end shows the page cut winning over the line length, and a small `free_dw` shows the space clip winning. The 12-bit window fields let the bench place addresses exactly on the base and limit granules, and just outside them. They also let it disable the window by setting base above limit.

// File: rtl/dly_rd_pkg.sv
// Package: command codes and controller states shared by the delayed
// read controller and its sub-blocks.
// Assumes the conventional 4-bit bus command encoding for reads.
package dly_rd_pkg;

    localparam logic [3:0] CMD_IO_RD   = 4'b0010;
    localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
    localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
    localparam logic [3:0] CMD_MEM_RDM = 4'b1100;
    localparam logic [3:0] CMD_MEM_RDL = 4'b1110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_FILL,
        ST_READY,
        ST_SEND
    } rd_state_e;

endpackage

// File: rtl/dly_rd_classify.sv
// Module: dly_rd_classify
// Decides whether a command is a read at all, and whether it takes the
// prefetchable path (speculative burst) or the single-DWORD path.
// Assumes win_key is the 1 MB granule of the address. Base and limit are
// inclusive, and base > limit turns the window off.
module dly_rd_classify #(
    parameter int WIN_W = 12
) (
    input  logic [3:0]       cmd,
    input  logic [WIN_W-1:0] win_key,
    input  logic [WIN_W-1:0] win_base,
    input  logic [WIN_W-1:0] win_limit,
    output logic             is_read,
    output logic             prefetch,
    output logic             multi_line
);
    import dly_rd_pkg::*;

    logic win_on;
    logic in_win;

    // Window hit: enabled window, inclusive bounds.
    always_comb begin
        win_on = (win_base <= win_limit);
        in_win = win_on && (win_key >= win_base) && (win_key <= win_limit);
    end

    // Command decode into read / path / multi-line flags.
    always_comb begin
        is_read    = 1'b0;
        prefetch   = 1'b0;
        multi_line = 1'b0;
        case (cmd)
            CMD_IO_RD, CMD_CFG_RD: is_read = 1'b1;
            CMD_MEM_RD: begin
                is_read  = 1'b1;
                prefetch = in_win;
            end
            CMD_MEM_RDL: begin
                is_read  = 1'b1;
                prefetch = 1'b1;
            end
            CMD_MEM_RDM: begin
                is_read    = 1'b1;
                prefetch   = 1'b1;
                multi_line = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dly_rd_len.sv
// Module: dly_rd_len
// Works out the burst length in DWORDs. The prefetchable path runs to the
// end of this line, or of the next line for multi-line reads. The result
// is clipped to the free buffer space and cut at the page boundary. The
// single-DWORD path always yields 1.
// Assumes LINE_DW and PAGE_DW are powers of two, 2*LINE_DW fits the buffer,
// and free_dw is non-zero whenever the result is used.
module dly_rd_len #(
    parameter int LINE_DW = 8,
    parameter int PAGE_DW = 1024,
    parameter int LEN_W   = 5,
    localparam int PG_W   = $clog2(PAGE_DW),
    localparam int LINE_W = $clog2(LINE_DW)
) (
    input  logic [PG_W-1:0]  addr_lo,
    input  logic             prefetch,
    input  logic             multi_line,
    input  logic [LEN_W-1:0] free_dw,
    output logic [LEN_W-1:0] len
);
    localparam int CW = PG_W + 2;

    logic [CW-1:0] want;
    logic [CW-1:0] page_left;
    logic [CW-1:0] room;
    logic [CW-1:0] pick;

    // Command-driven length, then the two clips, smallest wins.
    always_comb begin
        want      = CW'(multi_line ? 2 * LINE_DW : LINE_DW) - CW'(addr_lo[LINE_W-1:0]);
        page_left = CW'(PAGE_DW) - CW'(addr_lo);
        room      = CW'(free_dw);
        pick      = want;
        if (page_left < pick) pick = page_left;
        if (room < pick)      pick = room;
        len       = prefetch ? LEN_W'(pick) : LEN_W'(1);
    end

endmodule

// File: rtl/dly_rd_buf.sv
// Module: dly_rd_buf
// Read-data store: one write port fed by the target side, one
// combinational read port towards the initiator.
// Assumes the writer never writes and reads the same word in one cycle.
module dly_rd_buf #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    // Store a returned word.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // Present the word selected by the delivery pointer.
    always_comb rd_data = mem[rd_idx];

endmodule

// File: rtl/dly_read_ctrl.sv
// Module: dly_read_ctrl (top)
// Delayed read controller. It holds a single outstanding read entry:
// latch and retry, issue the target burst, fill the buffer, then deliver
// on the matching repeat with a disconnect on the last word.
// Assumes the target returns exactly tgt_len words after tgt_ack. Data
// arriving outside the fill phase is dropped.
module dly_read_ctrl #(
    parameter int AW      = 30,
    parameter int DW      = 32,
    parameter int WIN_W   = 12,
    parameter int LINE_DW = 8,
    parameter int BUF_DW  = 16,
    parameter int PAGE_DW = 1024,
    parameter int LEN_W   = $clog2(BUF_DW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ini_req,
    input  logic [3:0]       ini_cmd,
    input  logic [AW-1:0]    ini_addr,
    input  logic [3:0]       ini_be,
    output logic             ini_retry,
    output logic             ini_dv,
    output logic [DW-1:0]    ini_data,
    output logic             ini_last,
    input  logic [WIN_W-1:0] win_base,
    input  logic [WIN_W-1:0] win_limit,
    input  logic [LEN_W-1:0] free_dw,
    output logic             tgt_req,
    output logic [3:0]       tgt_cmd,
    output logic [AW-1:0]    tgt_addr,
    output logic [3:0]       tgt_be,
    output logic [LEN_W-1:0] tgt_len,
    input  logic             tgt_ack,
    input  logic             tgt_rvalid,
    input  logic [DW-1:0]    tgt_rdata
);
    import dly_rd_pkg::*;

    localparam int PTR_W = $clog2(BUF_DW);
    localparam int PG_W  = $clog2(PAGE_DW);

    rd_state_e        st;
    logic             is_read, pref, multi;
    logic [LEN_W-1:0] calc_len;
    logic [3:0]       e_cmd, e_be;
    logic [AW-1:0]    e_addr;
    logic [LEN_W-1:0] e_len;
    logic             e_pref;
    logic [LEN_W-1:0] ptr;
    logic             retry_q;
    logic             hit, at_end;

    dly_rd_classify #(.WIN_W(WIN_W)) u_class (
        .cmd        (ini_cmd),
        .win_key    (ini_addr[AW-1 -: WIN_W]),
        .win_base   (win_base),
        .win_limit  (win_limit),
        .is_read    (is_read),
        .prefetch   (pref),
        .multi_line (multi)
    );

    dly_rd_len #(.LINE_DW(LINE_DW), .PAGE_DW(PAGE_DW), .LEN_W(LEN_W)) u_len (
        .addr_lo    (ini_addr[PG_W-1:0]),
        .prefetch   (pref),
        .multi_line (multi),
        .free_dw    (free_dw),
        .len        (calc_len)
    );

    dly_rd_buf #(.DW(DW), .DEPTH(BUF_DW)) u_buf (
        .clk     (clk),
        .wr_en   (st == ST_FILL && tgt_rvalid),
        .wr_idx  (ptr[PTR_W-1:0]),
        .wr_data (tgt_rdata),
        .rd_idx  (ptr[PTR_W-1:0]),
        .rd_data (ini_data)
    );

    // Repeat-request match against the stored entry, and end-of-burst flag.
    always_comb begin
        hit    = (ini_cmd == e_cmd) && (ini_addr == e_addr) && (ini_be == e_be);
        at_end = (ptr == e_len - LEN_W'(1));
    end

    // Entry, pointer, retry and state sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            ptr     <= '0;
            retry_q <= 1'b0;
            e_cmd   <= '0;
            e_be    <= '0;
            e_addr  <= '0;
            e_len   <= '0;
            e_pref  <= 1'b0;
        end else begin
            retry_q <= ini_req && is_read && !(st == ST_READY && hit);
            case (st)
                ST_IDLE: begin
                    if (ini_req && is_read && free_dw != '0) begin
                        e_cmd  <= ini_cmd;
                        e_be   <= ini_be;
                        e_addr <= ini_addr;
                        e_len  <= calc_len;
                        e_pref <= pref;
                        st     <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (tgt_ack) begin
                        ptr <= '0;
                        st  <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (tgt_rvalid) begin
                        if (at_end) begin
                            ptr <= '0;
                            st  <= ST_READY;
                        end else begin
                            ptr <= ptr + LEN_W'(1);
                        end
                    end
                end
                ST_READY: begin
                    if (ini_req && hit) st <= ST_SEND;
                end
                ST_SEND: begin
                    if (at_end) begin
                        ptr <= '0;
                        st  <= ST_IDLE;
                    end else begin
                        ptr <= ptr + LEN_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Port drive from the stored entry and state.
    always_comb begin
        ini_retry = retry_q;
        ini_dv    = (st == ST_SEND);
        ini_last  = (st == ST_SEND) && at_end;
        tgt_req   = (st == ST_ISSUE);
        tgt_cmd   = e_cmd;
        tgt_addr  = e_addr;
        tgt_be    = e_pref ? 4'hF : e_be;
        tgt_len   = e_len;
    end

    // R4: any multi-word burst comes from the prefetchable path, all enables on.
    a_r4_burst_all_be: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req && tgt_len > LEN_W'(1) |-> tgt_be == 4'hF);

    // R5: partial enables only occur on single-DWORD requests.
    a_r5_partial_single: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req && tgt_be != 4'hF |-> tgt_len == LEN_W'(1));

    // R7: burst length is never zero and never exceeds the buffer.
    a_r7_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req |-> tgt_len != '0 && tgt_len <= LEN_W'(BUF_DW));

    // R8: request held with stable fields until accepted.
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req && !tgt_ack |=> tgt_req && $stable(tgt_addr) && $stable(tgt_len));

    // R9: while busy, every read request gets retry or starts delivery.
    a_r9_busy_answer: assert property (@(posedge clk) disable iff (!rst_n)
        ini_req && is_read && st != ST_IDLE && st != ST_SEND |=> ini_retry || ini_dv);

    // R10: the disconnect word ends delivery.
    a_r10_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        ini_dv && ini_last |=> !ini_dv);

    // R11: non-read commands in idle produce neither retry nor target request.
    a_r11_nonread_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_IDLE && ini_req && !is_read |=> !ini_retry && !tgt_req);

    // R12: no buffer space means no target request.
    a_r12_no_space: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_IDLE && free_dw == '0 |=> !tgt_req);

endmodule

// File: tb/dly_read_ctrl_bench.sv
// Bench for dly_read_ctrl: a vector table walked by one loop, then
// directed tests for reset, ignored commands, zero space, a disabled
// window and an outstanding entry under competing requests.
module dly_read_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ini_req = 1'b0;
    logic [3:0]  ini_cmd = '0;
    logic [29:0] ini_addr = '0;
    logic [3:0]  ini_be = '0;
    logic        ini_retry, ini_dv, ini_last;
    logic [31:0] ini_data;
    logic [11:0] win_base = 12'h010;
    logic [11:0] win_limit = 12'h01F;
    logic [4:0]  free_dw = 5'd16;
    logic        tgt_req;
    logic [3:0]  tgt_cmd, tgt_be;
    logic [29:0] tgt_addr;
    logic [4:0]  tgt_len;
    logic        tgt_ack = 1'b0;
    logic        tgt_rvalid = 1'b0;
    logic [31:0] tgt_rdata = '0;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    dly_read_ctrl u_dly_read_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ini_req(ini_req), .ini_cmd(ini_cmd), .ini_addr(ini_addr), .ini_be(ini_be),
        .ini_retry(ini_retry), .ini_dv(ini_dv), .ini_data(ini_data), .ini_last(ini_last),
        .win_base(win_base), .win_limit(win_limit), .free_dw(free_dw),
        .tgt_req(tgt_req), .tgt_cmd(tgt_cmd), .tgt_addr(tgt_addr), .tgt_be(tgt_be),
        .tgt_len(tgt_len), .tgt_ack(tgt_ack), .tgt_rvalid(tgt_rvalid), .tgt_rdata(tgt_rdata)
    );

    typedef struct packed {
        logic [3:0]  cmd;
        logic [29:0] addr;
        logic [3:0]  be;
        logic [4:0]  free;
        logic [4:0]  len;
        logic [3:0]  tbe;
    } vec_t;

    // Window 0x010..0x01F on address bits [29:18].
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'h6, 30'h00400003, 4'h3, 5'd16, 5'd5,  4'hF},  // R2 R4 R6 in window
        '{4'h6, 30'h00000005, 4'h3, 5'd16, 5'd1,  4'h3},  // R2 R5 outside
        '{4'hE, 30'h00000002, 4'h1, 5'd16, 5'd6,  4'hF},  // R1 R6 line
        '{4'hC, 30'h00000002, 4'h1, 5'd16, 5'd14, 4'hF},  // R1 R6 multiple
        '{4'hC, 30'h00000000, 4'hF, 5'd16, 5'd16, 4'hF},  // R6 full buffer
        '{4'hC, 30'h00000010, 4'hF, 5'd3,  5'd3,  4'hF},  // R7 space clip
        '{4'hC, 30'h000003FC, 4'h2, 5'd16, 5'd4,  4'hF},  // R7 page clip
        '{4'h2, 30'h00000007, 4'h8, 5'd16, 5'd1,  4'h8},  // R3 I/O
        '{4'hA, 30'h00000001, 4'h4, 5'd16, 5'd1,  4'h4},  // R3 config
        '{4'h6, 30'h007FFFFF, 4'h6, 5'd16, 5'd1,  4'hF},  // R2 at limit
        '{4'h6, 30'h00800000, 4'h5, 5'd16, 5'd1,  4'h5},  // R2 above limit
        '{4'h6, 30'h003FFFFF, 4'h9, 5'd16, 5'd1,  4'h9},  // R2 below base
        '{4'hE, 30'h00400006, 4'h0, 5'd1,  5'd1,  4'hF}   // R7 one free word
    };

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    // One-cycle request; returns at the negedge after the sampling edge.
    task automatic pulse(input logic [3:0] c, input logic [29:0] a, input logic [3:0] b);
        @(negedge clk);
        ini_req = 1'b1; ini_cmd = c; ini_addr = a; ini_be = b;
        @(negedge clk);
        ini_req = 1'b0;
    endtask

    task automatic ack_burst();
        tgt_ack = 1'b1;
        @(negedge clk);
        tgt_ack = 1'b0;
    endtask

    task automatic feed(input int tag, input int from, input int upto);
        for (int i = from; i < upto; i++) begin
            tgt_rvalid = 1'b1;
            tgt_rdata  = 32'hD000_0000 + 32'(tag * 256 + i);
            @(negedge clk);
        end
        tgt_rvalid = 1'b0;
    endtask

    task automatic collect(input int tag, input int n, input string rq);
        chk(ini_retry == 1'b0, "R10", "matched repeat retried", ini_retry, 0);
        for (int i = 0; i < n; i++) begin
            chk(ini_dv == 1'b1, rq, "data valid", ini_dv, 1);
            chk(ini_data == 32'hD000_0000 + 32'(tag * 256 + i), rq, "data word",
                ini_data, 32'hD000_0000 + 32'(tag * 256 + i));
            chk(ini_last == (i == n - 1), "R10", "last flag", ini_last, (i == n - 1));
            @(negedge clk);
        end
        chk(ini_dv == 1'b0, "R10", "valid after disconnect", ini_dv, 0);
    endtask

    task automatic run_read(input logic [3:0] c, input logic [29:0] a, input logic [3:0] b,
                            input int elen, input logic [3:0] ebe, input int tag,
                            input string rq);
        pulse(c, a, b);
        chk(ini_retry == 1'b1, "R8", "first request retry", ini_retry, 1);
        chk(tgt_req == 1'b1, "R8", "target request", tgt_req, 1);
        chk(tgt_cmd == c, "R8", "target cmd", tgt_cmd, c);
        chk(tgt_addr == a, "R8", "target addr", tgt_addr, a);
        chk(tgt_len == 5'(elen), rq, "target len", tgt_len, elen);
        chk(tgt_be == ebe, rq, "target be", tgt_be, ebe);
        ack_burst();
        chk(tgt_req == 1'b0, "R8", "request dropped after ack", tgt_req, 0);
        feed(tag, 0, elen);
        pulse(c, a, b);
        collect(tag, elen, rq);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog all-requirements act=timeout exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state.
        chk(tgt_req == 1'b0, "R8", "reset tgt_req", tgt_req, 0);
        chk(ini_dv == 1'b0, "R10", "reset ini_dv", ini_dv, 0);
        chk(ini_retry == 1'b0, "R8", "reset ini_retry", ini_retry, 0);

        // Vector table.
        for (int v = 0; v < NV; v++) begin
            free_dw = VECS[v].free;
            run_read(VECS[v].cmd, VECS[v].addr, VECS[v].be, int'(VECS[v].len),
                     VECS[v].tbe, v, "R1/R2/R3/R4/R5/R6/R7 table");
        end
        free_dw = 5'd16;

        // R11: a write command (4'b0111) is ignored.
        pulse(4'h7, 30'h00400000, 4'hF);
        chk(ini_retry == 1'b0, "R11", "non-read retried", ini_retry, 0);
        chk(tgt_req == 1'b0, "R11", "non-read forwarded", tgt_req, 0);

        // R12: no free space, retried and not latched.
        free_dw = 5'd0;
        pulse(4'h6, 30'h00400003, 4'h3);
        chk(ini_retry == 1'b1, "R12", "zero-space retry", ini_retry, 1);
        chk(tgt_req == 1'b0, "R12", "zero-space forwarded", tgt_req, 0);
        @(negedge clk);
        chk(tgt_req == 1'b0, "R12", "zero-space late forward", tgt_req, 0);
        free_dw = 5'd16;

        // R13: base above limit disables the window.
        win_base = 12'h020; win_limit = 12'h010;
        run_read(4'h6, 30'h00400003, 4'h3, 1, 4'h3, 30, "R13");
        win_base = 12'h010; win_limit = 12'h01F;

        // R9: outstanding entry under competing requests.
        pulse(4'hC, 30'h00000020, 4'hF);
        chk(ini_retry == 1'b1, "R9", "first retry", ini_retry, 1);
        pulse(4'h6, 30'h00000040, 4'h1);
        chk(ini_retry == 1'b1, "R9", "other request retried", ini_retry, 1);
        chk(tgt_addr == 30'h00000020, "R9", "entry kept addr", tgt_addr, 30'h20);
        chk(tgt_len == 5'd16, "R9", "entry kept len", tgt_len, 16);
        ack_burst();
        feed(40, 0, 8);
        pulse(4'hC, 30'h00000020, 4'hF);
        chk(ini_retry == 1'b1, "R9", "same request mid-fill retried", ini_retry, 1);
        chk(ini_dv == 1'b0, "R9", "no data mid-fill", ini_dv, 0);
        feed(40, 8, 16);
        pulse(4'hC, 30'h00000020, 4'h7);
        chk(ini_retry == 1'b1, "R9", "mismatch be retried", ini_retry, 1);
        chk(ini_dv == 1'b0, "R9", "mismatch delivers nothing", ini_dv, 0);
        pulse(4'hC, 30'h00000020, 4'hF);
        collect(40, 16, "R9");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

endmodule